// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Sequencer

This block controls a small on-chip nonvolatile byte array, which is modelled here as a register file, together with one extra hidden cell that holds the configuration byte. A CPU reaches it through a simple synchronous bus: select, write enable, address, write data and combinational read data. A one-cycle error pulse with a cause code reports protocol violations. The bus address has one window for the array cells and one register space that holds the control register and the configuration register.

Software changes a cell with a handshake in two steps. First it sets the latch-enable bit in the control register. The next cell write is then captured as a pending target and byte, and the array is not written. Software then raises the voltage-enable bit and holds it for a minimum number of clock cycles. When it drops that bit, the sequencer carries out one of four operations: a bit-clearing program, a byte erase, a 16-byte row erase or a bulk erase. Writes to the configuration register are sent to the hidden cell. The live configuration value is reloaded from that cell only at controller reset, and its enable bit decides whether the array can be read.

Top module: `eeprom_seq`

## Requirements
- R1: After power-on reset every array cell and the hidden cell read 0xFF, the control register reads 0, the configuration register reads 0xFF and `err` is low. The address map is: array cell k at address k (bit AW clear), control register at register offset 0, configuration register at register offset 1.
- R2: The control bits are: [0] byte mode, [1] row mode, [2] erase, [3] latch enable, [4] voltage enable. A control write that newly sets both bit 3 and bit 4 is rejected with code 1, and the control register does not change.
- R3: A control write with bit 3 clear forces the whole control register to 0.
- R4: A control write that sets voltage enable while no target is pending raises code 2, and the register still takes the written value.
- R5: With latch enable set, the first cell write is captured and does not change the array. A further cell write before completion raises code 4. A cell write while latch enable is clear raises code 3 and changes nothing. The pending state clears on completion.
- R6: Completion happens on a control write that drops voltage enable while voltage enable is set. The elapsed cycle count is measured between the clock edge of the raising write and the clock edge of the dropping write. If it is below MIN_CYC, code 5 is raised, and the operation still takes place.
- R7: A completion with erase clear ANDs the latched byte into the target cell.
- R8: A completion with erase set erases only the target cell to 0xFF when byte mode is set or when the target is the hidden configuration cell, even if row mode is also set.
- R9: A completion with erase and row mode set, and byte mode clear, sets to 0xFF every array cell in the 16-byte-aligned row of the target.
- R10: A completion with erase set and both mode bits clear sets every cell to 0xFF, including the hidden cell.
- R11: Writes to the configuration register target the hidden cell through the same handshake. The configuration register keeps its value until `rst_n` is pulsed, and then loads the hidden cell.
- R12: Array reads return the cell when configuration bit 0 is 1, and return 0 otherwise.
- R13: An array read while latch enable is set raises code 6.
- R14: `err` is high for one cycle, in the cycle after the faulty access, and `err_code` is nonzero exactly when `err` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; also fills the array and hidden cell with 0xFF |
| rst_n | input | 1 | Synchronous controller reset, active low; reloads the configuration from the hidden cell |
| sel | input | 1 | Bus access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | AW+1 | Bit AW selects register space; low bits select cell or register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Cause of the error: 1 reject, 2 no target, 3 refused write, 4 second write, 5 too short, 6 read while latched |

## Verification
The elapsed-cycle counter reaching MIN_CYC can coincide with the completion write that drops voltage enable. The test provokes this by holding voltage enable for exactly MIN_CYC cycles and then for exactly one cycle fewer. The first case must complete silently and the second must pulse code 5, and the cell must be updated in both cases. The test also makes the erase decode see row mode and a configuration-cell target in the same completion, and it checks that the byte path wins.

// File: rtl/eeprom_seq.sv
module eeprom_seq #(
  parameter int AW      = 6,
  parameter int MIN_CYC = 10000
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW:0]   addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          err,
  output logic [2:0]    err_code
);
  localparam int N  = 1 << AW;
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [AW:0] CFG_IDX = (AW+1)'(N);

  logic [7:0]    mem [0:N];
  logic [4:0]    ctrl_q;
  logic          pending_q;
  logic [AW:0]   la_q;
  logic [7:0]    ld_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cfg_q;
  logic          err_q;
  logic [2:0]    code_q;
  logic [2:0]    code_d;

  wire is_arr  = !addr[AW];
  wire is_ctl  = addr[AW] && addr[AW-1:0] == '0;
  wire is_cfg  = addr[AW] && addr[AW-1:0] == AW'(1);
  wire wr      = sel && we;
  wire rd      = sel && !we;
  wire ctl_wr  = wr && is_ctl;
  wire cell_wr = wr && (is_arr || is_cfg);

  wire       reject  = ctl_wr && (&(wdata[4:3] & ~ctrl_q[4:3]));
  wire [4:0] nv      = wdata[3] ? wdata[4:0] : 5'd0;
  wire       ctl_ok  = ctl_wr && !reject;
  wire       finish  = ctl_ok && !nv[4] && ctrl_q[4];
  wire       do_op   = finish && pending_q;
  wire       short_t = (32'(cnt_q) + 32'd1) < 32'(MIN_CYC);
  wire       capture = cell_wr && ctrl_q[3] && !pending_q;
  wire       byte_er = ctrl_q[0] || la_q == CFG_IDX;
  wire       ctl_rst = !rst_n || !por_n;

  always_comb begin
    if (reject)                          code_d = 3'd1;
    else if (ctl_ok && nv[4] && !pending_q) code_d = 3'd2;
    else if (finish && short_t)          code_d = 3'd5;
    else if (cell_wr && !ctrl_q[3])      code_d = 3'd3;
    else if (cell_wr && pending_q)       code_d = 3'd4;
    else if (rd && is_arr && ctrl_q[3])  code_d = 3'd6;
    else                                 code_d = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (ctl_rst) begin
      ctrl_q    <= '0;
      pending_q <= 1'b0;
      la_q      <= '0;
      ld_q      <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      code_q    <= '0;
    end else begin
      err_q  <= code_d != 3'd0;
      code_q <= code_d;
      if (ctl_ok) ctrl_q <= nv;
      if (ctl_ok && nv[4]) cnt_q <= '0;
      else if (ctrl_q[4] && 32'(cnt_q) < 32'(MIN_CYC)) cnt_q <= cnt_q + CW'(1);
      if (capture) begin
        pending_q <= 1'b1;
        la_q      <= is_cfg ? CFG_IDX : {1'b0, addr[AW-1:0]};
        ld_q      <= wdata;
      end else if (do_op) begin
        pending_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)     cfg_q <= 8'hFF;
    else if (!rst_n) cfg_q <= mem[N];
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i <= N; i++) mem[i] <= 8'hFF;
    end else if (do_op) begin
      for (int i = 0; i <= N; i++) begin
        if (!ctrl_q[2]) begin
          if (la_q == (AW+1)'(i)) mem[i] <= mem[i] & ld_q;
        end else if (byte_er) begin
          if (la_q == (AW+1)'(i)) mem[i] <= 8'hFF;
        end else if (ctrl_q[1]) begin
          if (i < N && la_q[AW:4] == (AW-3)'(i >> 4)) mem[i] <= 8'hFF;
        end else begin
          mem[i] <= 8'hFF;
        end
      end
    end
  end

  always_comb begin
    if (is_arr)      rdata = cfg_q[0] ? mem[{1'b0, addr[AW-1:0]}] : 8'h00;
    else if (is_ctl) rdata = {3'b000, ctrl_q};
    else if (is_cfg) rdata = cfg_q;
    else             rdata = 8'h00;
  end

  assign err      = err_q;
  assign err_code = code_q;
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        sel,
  input logic        we,
  input logic [AW:0] addr,
  input logic [7:0]  wdata,
  input logic        err,
  input logic [2:0]  err_code,
  input logic [4:0]  ctrl_q,
  input logic        pending_q
);
  wire ctl_acc  = sel && we && addr[AW] && addr[AW-1:0] == '0;
  wire cell_acc = sel && we && (!addr[AW] || addr[AW-1:0] == AW'(1));

  p_reject_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctl_acc && wdata[3] && wdata[4] && ctrl_q[4:3] == 2'b00
    |=> err && err_code == 3'd1 && $stable(ctrl_q));

  p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctl_acc && !wdata[3] |=> ctrl_q == 5'd0);

  p_refused_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cell_acc && !ctrl_q[3] |=> err && err_code == 3'd3);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctl_acc && ctrl_q[4] && !(wdata[4] && wdata[3]) |=> !pending_q);

  p_read_latched_r13: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sel && !we && !addr[AW] && ctrl_q[3] |=> err && err_code == 3'd6);

  p_code_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !err |-> err_code == 3'd0);

  p_code_set_r14: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    err |-> err_code != 3'd0);
endmodule

bind eeprom_seq eeprom_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
  .wdata(wdata), .err(err), .err_code(err_code), .ctrl_q(ctrl_q),
  .pending_q(pending_q)
);

// File: tb/eeprom_seq_bench.sv
module eeprom_seq_bench;
  localparam int AW  = 6;
  localparam int MIN = 40;
  localparam logic [AW:0] CTL = 7'h40;
  localparam logic [AW:0] CFG = 7'h41;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [AW:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic err;
  logic [2:0] err_code;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  eeprom_seq #(.AW(AW), .MIN_CYC(MIN)) u_eeprom_seq (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .err_code(err_code));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW:0] a, input logic [7:0] d, output logic [2:0] c);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    c = err ? err_code : 3'd0;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW:0] a, output logic [7:0] d, output logic [2:0] c);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    c = err ? err_code : 3'd0;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op(input logic [4:0] mode, input logic [AW:0] a, input logic [7:0] d,
                    input int hold, output logic [2:0] fin);
    logic [2:0] c;
    wr(CTL, {3'b0, 5'h08 | mode}, c);
    wr(a, d, c);
    wr(CTL, {3'b0, 5'h18 | mode}, c);
    idle(hold);
    wr(CTL, {3'b0, 5'h08 | mode}, fin);
    wr(CTL, 8'h00, c);
  endtask

  task automatic ctl_reset();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [2:0] c;
    rd(CTL, d, c); chk("R1 ctl", d, 8'h00);
    rd(CFG, d, c); chk("R1 cfg", d, 8'hFF);
    rd(7'd5, d, c); chk("R1 cell", d, 8'hFF);
    chk("R1 err", {5'b0, c}, 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] d; logic [2:0] c, f;
    op(5'h00, 7'd5, 8'hF0, MIN-1, f);
    chk("R6 exact hold no error", {5'b0, f}, 8'h00);
    rd(7'd5, d, c); chk("R7 first program", d, 8'hF0);
    op(5'h00, 7'd5, 8'h3C, MIN-1, f);
    rd(7'd5, d, c); chk("R7 and", d, 8'h30);
  endtask

  task automatic t_ctrl();
    logic [7:0] d; logic [2:0] c;
    wr(CTL, 8'h18, c); chk("R2 reject code", {5'b0, c}, 8'h01);
    idle(1); chk("R14 pulse ends", {7'b0, err}, 8'h00);
    rd(CTL, d, c); chk("R2 unchanged", d, 8'h00);
    wr(CTL, 8'h08, c);
    wr(CTL, 8'h18, c); chk("R4 no target code", {5'b0, c}, 8'h02);
    rd(CTL, d, c); chk("R4 value kept", d, 8'h18);
    wr(CTL, 8'h00, c); chk("R6 short without target", {5'b0, c}, 8'h05);
    rd(7'd5, d, c); chk("R6 no target no change", d, 8'h30);
    wr(CTL, 8'h0E, c);
    rd(CTL, d, c); chk("R2 mode bits", d, 8'h0E);
    wr(CTL, 8'h06, c);
    rd(CTL, d, c); chk("R3 forced zero", d, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d; logic [2:0] c;
    wr(7'd7, 8'h00, c); chk("R5 refused code", {5'b0, c}, 8'h03);
    rd(7'd7, d, c); chk("R5 refused no change", d, 8'hFF);
    wr(CTL, 8'h08, c);
    wr(7'd7, 8'h00, c); chk("R5 capture silent", {5'b0, c}, 8'h00);
    rd(7'd7, d, c);
    chk("R13 read code", {5'b0, c}, 8'h06);
    chk("R5 captured not stored", d, 8'hFF);
    wr(7'd8, 8'h00, c); chk("R5 second write code", {5'b0, c}, 8'h04);
    wr(CTL, 8'h18, c);
    idle(MIN-1);
    wr(CTL, 8'h08, c);
    wr(CTL, 8'h00, c);
    rd(7'd7, d, c); chk("R5 first target programmed", d, 8'h00);
    rd(7'd8, d, c); chk("R5 second ignored", d, 8'hFF);
  endtask

  task automatic t_short();
    logic [7:0] d; logic [2:0] c, f;
    op(5'h00, 7'd9, 8'h0F, MIN-2, f);
    chk("R6 too short code", {5'b0, f}, 8'h05);
    rd(7'd9, d, c); chk("R6 still done", d, 8'h0F);
  endtask

  task automatic t_row_byte();
    logic [7:0] d; logic [2:0] c, f;
    op(5'h00, 7'd15, 8'h00, MIN-1, f);
    op(5'h00, 7'd16, 8'h00, MIN-1, f);
    op(5'h00, 7'd31, 8'h00, MIN-1, f);
    op(5'h00, 7'd32, 8'h00, MIN-1, f);
    op(5'h06, 7'd20, 8'h55, MIN-1, f);
    rd(7'd16, d, c); chk("R9 row low", d, 8'hFF);
    rd(7'd31, d, c); chk("R9 row high", d, 8'hFF);
    rd(7'd15, d, c); chk("R9 below row", d, 8'h00);
    rd(7'd32, d, c); chk("R9 above row", d, 8'h00);
    op(5'h05, 7'd15, 8'h00, MIN-1, f);
    rd(7'd15, d, c); chk("R8 byte erase", d, 8'hFF);
    rd(7'd32, d, c); chk("R8 neighbour kept", d, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d; logic [2:0] c, f;
    op(5'h00, CFG, 8'hFE, MIN-1, f);
    rd(CFG, d, c); chk("R11 not live yet", d, 8'hFF);
    rd(7'd32, d, c); chk("R12 enabled read", d, 8'h00);
    ctl_reset();
    rd(CFG, d, c); chk("R11 reloaded", d, 8'hFE);
    rd(7'd32, d, c); chk("R12 disabled read", d, 8'h00);
    rd(7'd5, d, c); chk("R12 disabled hides data", d, 8'h00);
    op(5'h06, CFG, 8'h00, MIN-1, f);
    ctl_reset();
    rd(CFG, d, c); chk("R8 cfg cell byte path", d, 8'hFF);
    rd(7'd5, d, c); chk("R12 enabled again", d, 8'h30);
  endtask

  task automatic t_bulk();
    logic [7:0] d; logic [2:0] c, f;
    op(5'h00, CFG, 8'hFE, MIN-1, f);
    op(5'h04, 7'd3, 8'h00, MIN-1, f);
    rd(7'd5, d, c);  chk("R10 cell 5", d, 8'hFF);
    rd(7'd32, d, c); chk("R10 cell 32", d, 8'hFF);
    rd(7'd7, d, c);  chk("R10 cell 7", d, 8'hFF);
    ctl_reset();
    rd(CFG, d, c); chk("R10 hidden cell", d, 8'hFF);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_ctrl();
    t_latch();
    t_short();
    t_row_byte();
    t_cfg();
    t_bulk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule